// File: doc/BRIEF.md
# Command-Response Buffer Register Controller

This block is the register front end of a trusted-module command/response buffer interface. A host reaches it through a simple word-write, byte-shifted-read register port. The block keeps track of which locality owns the interface, whether the module is idle or ready, and the start/cancel handshake for the single command that may be in flight. It also presents a fixed capability word and the size and base address of the shared data buffer.

Each locality owns its own 4 KiB page of the register window. The page number of a write is the writer's locality. The register offsets repeat in every page. A launch succeeds only for the page that currently owns the interface. The block then raises a one-cycle start pulse to a backend command processor and holds its start bit until the backend returns a completion pulse. A completion may carry an error flag, which latches a fatal-error status. The shared data memory and the backend processor lie outside this block.

Top module: `cmdbuf_regctl`

## Requirements
- R1: After reset the register values are as follows. Status word (offset 0x000) = 0x80: bit 7 is register-valid and bit 0 is the inverted established input, which the bench holds at 1. Control status (0x044) = 0x2: bit 1 is idle and bit 0 is fatal. Capability word (0x030) = 0x00025811. Command size (0x058) and response size (0x064) = 0xF80. Command address (0x05C) and response address (0x068) = 0xFED40080. Access status (0x00C) = 0 and start (0x04C) = 0.
- R2: A read returns the aligned 32-bit word shifted right by 8 × address[1:0]. Every locality page reads the same registers.
- R3: Bit 0 of the status word reads as the inverse of `established_i`.
- R4: Writes to locality control (0x008) act only on three exact values. The value 0x1 sets locality-assigned (status bit 1), copies the writer's page into the active-locality field (status bits 4:2), sets granted (access status bit 0) and clears been-seized (access status bit 1). The value 0x2 clears locality-assigned and granted and leaves the active-locality field unchanged. The value 0x8 changes nothing.
- R5: A write of exactly 0x1 to control request (0x040) clears idle. A write of exactly 0x2 sets idle. Any other value has no effect.
- R6: A write to start (0x04C) launches a command only when all three of these hold: the value is exactly 0x1, start is clear, and the writer's page equals the active locality. A launch sets start bit 0 and gives a single-cycle `bkd_start_o` pulse in the cycle after the write.
- R7: While no locality is assigned, the active locality is taken as 0xFF, so no start write launches a command.
- R8: A write of exactly 0x1 to cancel (0x048) gives a single-cycle `bkd_cancel_o` pulse, but only while start is set. Otherwise the write is ignored.
- R9: A `bkd_done_i` pulse while start is set clears start. If `bkd_err_i` is also high, the fatal bit is set and stays set until reset. A completion that arrives while start is clear has no effect.
- R10: Writes to read-only words (capability, sizes, addresses) and to undecoded offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 12+LOC_W | Byte address; the bits above bit 11 select the locality |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, shifted by the low address bits |
| established_i | input | 1 | Established flag from the module core |
| bkd_start_o | output | 1 | One-cycle command launch pulse |
| bkd_cancel_o | output | 1 | One-cycle cancel request pulse |
| bkd_done_i | input | 1 | One-cycle completion pulse from the backend |
| bkd_err_i | input | 1 | Completion carries an error |

## Verification
The bound checker watches every cycle for the properties of the pulse handshake. Start and cancel pulses last exactly one cycle. A start pulse only comes with start held. Start only rises from an owned interface. Cancel only follows a busy cycle. Completion clears start, and the fatal bit sets on an error and then stays set. The exact register encodings, the read byte shifting, the locality page match, the exact-value filtering of control writes and the immunity of read-only words can only be shown by the bench's scenarios, which compare read-back words and pulses against values computed from the requirements.

// File: rtl/cmdbuf_pkg.sv
// Package: register offsets, field positions and fixed words for the
// command-response buffer register controller.
// Assumes a 4 KiB page per locality with identical offsets in each page.
package cmdbuf_pkg;
    localparam int PAGE_BITS = 12;

    localparam logic [11:0] OFS_STATUS   = 12'h000;
    localparam logic [11:0] OFS_LOC_CTL  = 12'h008;
    localparam logic [11:0] OFS_ACC_STS  = 12'h00C;
    localparam logic [11:0] OFS_CAPS     = 12'h030;
    localparam logic [11:0] OFS_REQ      = 12'h040;
    localparam logic [11:0] OFS_CTL_STS  = 12'h044;
    localparam logic [11:0] OFS_CANCEL   = 12'h048;
    localparam logic [11:0] OFS_START    = 12'h04C;
    localparam logic [11:0] OFS_CMD_SIZE = 12'h058;
    localparam logic [11:0] OFS_CMD_ADDR = 12'h05C;
    localparam logic [11:0] OFS_RSP_SIZE = 12'h064;
    localparam logic [11:0] OFS_RSP_ADDR = 12'h068;

    // exact command values written to the control registers
    localparam logic [31:0] CMD_BIT0 = 32'h1;
    localparam logic [31:0] CMD_BIT1 = 32'h2;
    localparam logic [31:0] CMD_BIT3 = 32'h8;

    // active locality value when nothing is assigned
    localparam logic [7:0] NO_OWNER = 8'hFF;

    // capability word fields
    localparam logic [3:0] CAP_IF_KIND   = 4'h1;  // buffer interface active
    localparam logic [3:0] CAP_IF_REV    = 4'h1;  // buffer interface revision 1
    localparam logic [1:0] CAP_XFER_64   = 2'b11; // 64-byte transfers
    localparam logic [1:0] CAP_SELECTOR  = 2'b01; // buffer interface selected

    function automatic logic [31:0] caps_word();
        logic [31:0] w;
        w        = '0;
        w[3:0]   = CAP_IF_KIND;
        w[7:4]   = CAP_IF_REV;
        w[8]     = 1'b0;        // locality 0 only
        w[9]     = 1'b0;        // fast idle
        w[12:11] = CAP_XFER_64;
        w[13]    = 1'b0;        // no FIFO
        w[14]    = 1'b1;        // buffer interface supported
        w[18:17] = CAP_SELECTOR;
        return w;
    endfunction
endpackage

// File: rtl/cmdbuf_loc_ctl.sv
// Locality ownership tracker.
// Acts only on exact request/relinquish values. The reset-establishment
// value and all other values are ignored. Been-seized is never set here
// because seizing is not supported; request clears it.
module cmdbuf_loc_ctl #(
    parameter int LOC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_loc_ctl,
    input  logic [31:0]      wdata,
    input  logic [LOC_W-1:0] wr_loc,
    output logic             assigned,
    output logic             granted,
    output logic             seized,
    output logic [LOC_W-1:0] active_loc
);
    import cmdbuf_pkg::*;

    // ownership state update on exact locality-control values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assigned   <= 1'b0;
            granted    <= 1'b0;
            seized     <= 1'b0;
            active_loc <= '0;
        end else if (wr_loc_ctl) begin
            if (wdata == CMD_BIT0) begin
                assigned   <= 1'b1;
                granted    <= 1'b1;
                seized     <= 1'b0;
                active_loc <= wr_loc;
            end else if (wdata == CMD_BIT1) begin
                assigned <= 1'b0;
                granted  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cmdbuf_cmd_ctl.sv
// Command handshake: idle/ready state, start hold, cancel forwarding and
// fatal latch. Assumes done_i is a one-cycle pulse. A done while start is
// clear is dropped. Start and cancel outputs are registered one-cycle pulses.
module cmdbuf_cmd_ctl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_req,
    input  logic        wr_cancel,
    input  logic        wr_start,
    input  logic [31:0] wdata,
    input  logic        owner_match,
    input  logic        done_i,
    input  logic        err_i,
    output logic        start_busy,
    output logic        fatal,
    output logic        idle,
    output logic        start_o,
    output logic        cancel_o
);
    import cmdbuf_pkg::*;

    logic launch;
    assign launch = wr_start && (wdata == CMD_BIT0) && !start_busy && owner_match;

    // idle/ready state from exact control-request values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle <= 1'b1;
        end else if (wr_req) begin
            if (wdata == CMD_BIT0)      idle <= 1'b0;
            else if (wdata == CMD_BIT1) idle <= 1'b1;
        end
    end

    // start hold: set by a launch, cleared by a completion
    always_ff @(posedge clk) begin
        if (!rst_n)                    start_busy <= 1'b0;
        else if (launch)               start_busy <= 1'b1;
        else if (done_i && start_busy) start_busy <= 1'b0;
    end

    // fatal latch, sticky until reset
    always_ff @(posedge clk) begin
        if (!rst_n)                               fatal <= 1'b0;
        else if (done_i && err_i && start_busy)   fatal <= 1'b1;
    end

    // one-cycle strobes to the backend
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o  <= 1'b0;
            cancel_o <= 1'b0;
        end else begin
            start_o  <= launch;
            cancel_o <= wr_cancel && (wdata == CMD_BIT0) && start_busy;
        end
    end
endmodule

// File: rtl/cmdbuf_rd_mux.sv
// Read path: selects the aligned word by offset and shifts it right by
// whole bytes for narrow little-endian reads. Purely combinational.
module cmdbuf_rd_mux #(
    parameter int          LOC_W    = 3,
    parameter logic [31:0] BUF_SIZE = 32'h0000_0F80,
    parameter logic [31:0] BUF_BASE = 32'hFED4_0080
) (
    input  logic [11:0]      offset,
    input  logic             established,
    input  logic             assigned,
    input  logic [LOC_W-1:0] active_loc,
    input  logic             granted,
    input  logic             seized,
    input  logic             idle,
    input  logic             fatal,
    input  logic             start_busy,
    output logic [31:0]      rdata
);
    import cmdbuf_pkg::*;

    logic [31:0] word;

    // word selection by aligned offset
    always_comb begin
        word = '0;
        unique case ({offset[11:2], 2'b00})
            OFS_STATUS: begin
                word[0]           = ~established;
                word[1]           = assigned;
                word[2 +: LOC_W]  = active_loc;
                word[7]           = 1'b1;
            end
            OFS_ACC_STS:  word = {30'd0, seized, granted};
            OFS_CAPS:     word = caps_word();
            OFS_CTL_STS:  word = {30'd0, idle, fatal};
            OFS_START:    word = {31'd0, start_busy};
            OFS_CMD_SIZE: word = BUF_SIZE;
            OFS_CMD_ADDR: word = BUF_BASE;
            OFS_RSP_SIZE: word = BUF_SIZE;
            OFS_RSP_ADDR: word = BUF_BASE;
            default:      word = '0;
        endcase
    end

    assign rdata = word >> {offset[1:0], 3'b000};
endmodule

// File: rtl/cmdbuf_regctl.sv
// Top: decodes host writes per locality page, compares the writer page
// against the owning locality, and ties the locality, command and read
// blocks together. Assumes word-wide writes and one access per cycle.
module cmdbuf_regctl #(
    parameter int          LOC_W    = 3,
    parameter logic [31:0] BUF_SIZE = 32'h0000_0F80,
    parameter logic [31:0] BUF_BASE = 32'hFED4_0080,
    localparam int         ADDR_W   = 12 + LOC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              established_i,
    output logic              bkd_start_o,
    output logic              bkd_cancel_o,
    input  logic              bkd_done_i,
    input  logic              bkd_err_i
);
    import cmdbuf_pkg::*;

    logic [11:0]      offset;
    logic [LOC_W-1:0] wr_loc;
    logic             wr_loc_ctl, wr_req, wr_cancel, wr_start;
    logic             loc_assigned, granted, seized;
    logic [LOC_W-1:0] active_loc;
    logic [7:0]       owner_id;
    logic             owner_match;
    logic             start_busy, fatal, idle;

    assign offset = bus_addr[11:0];
    assign wr_loc = bus_addr[ADDR_W-1:PAGE_BITS];

    // write decode: one strobe per writable control register
    assign wr_loc_ctl = bus_wr_en && (offset == OFS_LOC_CTL);
    assign wr_req     = bus_wr_en && (offset == OFS_REQ);
    assign wr_cancel  = bus_wr_en && (offset == OFS_CANCEL);
    assign wr_start   = bus_wr_en && (offset == OFS_START);

    // owning locality, reserved value when unassigned
    assign owner_id    = loc_assigned ? 8'(active_loc) : NO_OWNER;
    assign owner_match = (owner_id == 8'(wr_loc));

    cmdbuf_loc_ctl #(.LOC_W(LOC_W)) u_loc (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_loc_ctl (wr_loc_ctl),
        .wdata      (bus_wdata),
        .wr_loc     (wr_loc),
        .assigned   (loc_assigned),
        .granted    (granted),
        .seized     (seized),
        .active_loc (active_loc)
    );

    cmdbuf_cmd_ctl u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_req      (wr_req),
        .wr_cancel   (wr_cancel),
        .wr_start    (wr_start),
        .wdata       (bus_wdata),
        .owner_match (owner_match),
        .done_i      (bkd_done_i),
        .err_i       (bkd_err_i),
        .start_busy  (start_busy),
        .fatal       (fatal),
        .idle        (idle),
        .start_o     (bkd_start_o),
        .cancel_o    (bkd_cancel_o)
    );

    cmdbuf_rd_mux #(.LOC_W(LOC_W), .BUF_SIZE(BUF_SIZE), .BUF_BASE(BUF_BASE)) u_rd (
        .offset      (offset),
        .established (established_i),
        .assigned    (loc_assigned),
        .active_loc  (active_loc),
        .granted     (granted),
        .seized      (seized),
        .idle        (idle),
        .fatal       (fatal),
        .start_busy  (start_busy),
        .rdata       (bus_rdata)
    );
endmodule

// File: rtl/cmdbuf_regctl_chk.sv
// Checker for the command handshake of cmdbuf_regctl, attached by bind.
// Assumes it observes the internal start, fatal and ownership state.
module cmdbuf_regctl_chk (
    input logic clk,
    input logic rst_n,
    input logic bkd_start_o,
    input logic bkd_cancel_o,
    input logic bkd_done_i,
    input logic bkd_err_i,
    input logic start_busy,
    input logic fatal,
    input logic loc_assigned
);
    a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        bkd_start_o |=> !bkd_start_o);
    a_r6_start_held: assert property (@(posedge clk) disable iff (!rst_n)
        bkd_start_o |-> start_busy);
    a_r7_start_needs_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_busy) |-> $past(loc_assigned));
    a_r8_cancel_single: assert property (@(posedge clk) disable iff (!rst_n)
        bkd_cancel_o |=> !bkd_cancel_o);
    a_r8_cancel_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        bkd_cancel_o |-> $past(start_busy));
    a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bkd_done_i && start_busy) |=> !start_busy);
    a_r9_err_sets_fatal: assert property (@(posedge clk) disable iff (!rst_n)
        (bkd_done_i && bkd_err_i && start_busy) |=> fatal);
    a_r9_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal);
endmodule

bind cmdbuf_regctl cmdbuf_regctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bkd_start_o  (bkd_start_o),
    .bkd_cancel_o (bkd_cancel_o),
    .bkd_done_i   (bkd_done_i),
    .bkd_err_i    (bkd_err_i),
    .start_busy   (start_busy),
    .fatal        (fatal),
    .loc_assigned (loc_assigned)
);

// File: tb/cmdbuf_regctl_tb.sv
module cmdbuf_regctl_tb;
    localparam int LOC_W  = 3;
    localparam int ADDR_W = 12 + LOC_W;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       data;
        logic [31:0]       exp;
        logic [7:0]        req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 15'h0000, 32'h0, 32'h0000_0080, 8'd1},  // R1 status
        '{1'b0, 15'h0044, 32'h0, 32'h0000_0002, 8'd1},  // R1 idle
        '{1'b0, 15'h0030, 32'h0, 32'h0002_5811, 8'd1},  // R1 caps
        '{1'b0, 15'h0058, 32'h0, 32'h0000_0F80, 8'd1},  // R1 cmd size
        '{1'b0, 15'h005C, 32'h0, 32'hFED4_0080, 8'd1},  // R1 cmd addr
        '{1'b0, 15'h0064, 32'h0, 32'h0000_0F80, 8'd1},  // R1 rsp size
        '{1'b0, 15'h0068, 32'h0, 32'hFED4_0080, 8'd1},  // R1 rsp addr
        '{1'b0, 15'h000C, 32'h0, 32'h0000_0000, 8'd1},  // R1 access
        '{1'b0, 15'h004C, 32'h0, 32'h0000_0000, 8'd1},  // R1 start
        '{1'b0, 15'h0031, 32'h0, 32'h0000_0258, 8'd2},  // R2 shift 8
        '{1'b0, 15'h0032, 32'h0, 32'h0000_0002, 8'd2},  // R2 shift 16
        '{1'b0, 15'h3030, 32'h0, 32'h0002_5811, 8'd2},  // R2 other page
        '{1'b1, 15'h0040, 32'h1, 32'h0,         8'd5},  // R5 ready
        '{1'b0, 15'h0044, 32'h0, 32'h0000_0000, 8'd5},
        '{1'b1, 15'h0040, 32'h3, 32'h0,         8'd5},  // R5 other value
        '{1'b0, 15'h0044, 32'h0, 32'h0000_0000, 8'd5},
        '{1'b1, 15'h0040, 32'h2, 32'h0,         8'd5},  // R5 go idle
        '{1'b0, 15'h0044, 32'h0, 32'h0000_0002, 8'd5},
        '{1'b1, 15'h0008, 32'h8, 32'h0,         8'd4},  // R4 reset-establishment
        '{1'b0, 15'h0000, 32'h0, 32'h0000_0080, 8'd4},
        '{1'b1, 15'h0008, 32'h1, 32'h0,         8'd4},  // R4 request page 0
        '{1'b0, 15'h0000, 32'h0, 32'h0000_0082, 8'd4},
        '{1'b0, 15'h000C, 32'h0, 32'h0000_0001, 8'd4},
        '{1'b1, 15'h2008, 32'h1, 32'h0,         8'd4},  // R4 request page 2
        '{1'b0, 15'h0000, 32'h0, 32'h0000_008A, 8'd4},
        '{1'b1, 15'h0008, 32'h2, 32'h0,         8'd4},  // R4 relinquish
        '{1'b0, 15'h0000, 32'h0, 32'h0000_0088, 8'd4},
        '{1'b0, 15'h000C, 32'h0, 32'h0000_0000, 8'd4},
        '{1'b1, 15'h0030, 32'hFFFF_FFFF, 32'h0, 8'd10}, // R10 caps write
        '{1'b0, 15'h0030, 32'h0, 32'h0002_5811, 8'd10},
        '{1'b1, 15'h0100, 32'hFFFF_FFFF, 32'h0, 8'd10}, // R10 undecoded
        '{1'b0, 15'h0044, 32'h0, 32'h0000_0002, 8'd10},
        '{1'b1, 15'h0058, 32'h0, 32'h0,         8'd10}, // R10 size write
        '{1'b0, 15'h0058, 32'h0, 32'h0000_0F80, 8'd10}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr_en = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              established_i = 1'b1;
    logic              bkd_start_o, bkd_cancel_o;
    logic              bkd_done_i = 1'b0;
    logic              bkd_err_i = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmdbuf_regctl #(.LOC_W(LOC_W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr_en     (bus_wr_en),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .established_i (established_i),
        .bkd_start_o   (bkd_start_o),
        .bkd_cancel_o  (bkd_cancel_o),
        .bkd_done_i    (bkd_done_i),
        .bkd_err_i     (bkd_err_i)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // write lands at the next posedge; returns at the following negedge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic complete(input logic err);
        @(negedge clk);
        bkd_done_i = 1'b1; bkd_err_i = err;
        @(negedge clk);
        bkd_done_i = 1'b0; bkd_err_i = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
            else begin
                rd(VEC[i].addr, v);
                check($sformatf("vector %0d R%0d", i, VEC[i].req), v, VEC[i].exp);
            end
        end

        // R3 established flag inverted into status bit 0
        established_i = 1'b0;
        rd(15'h0000, v); check("R3 established low", {31'd0, v[0]}, 32'd1);
        established_i = 1'b1;

        // R7 no owner: start refused
        wr(15'h004C, 32'h1); check("R7 no pulse", {31'd0, bkd_start_o}, 32'd0);
        rd(15'h004C, v);     check("R7 start clear", v, 32'd0);

        // R6 owner page 1
        wr(15'h1008, 32'h1);
        wr(15'h004C, 32'h1); check("R6 wrong page", {31'd0, bkd_start_o}, 32'd0);
        wr(15'h104C, 32'h2); check("R6 wrong value", {31'd0, bkd_start_o}, 32'd0);
        wr(15'h104C, 32'h1); check("R6 launch pulse", {31'd0, bkd_start_o}, 32'd1);
        @(negedge clk);      check("R6 pulse single", {31'd0, bkd_start_o}, 32'd0);
        rd(15'h004C, v);     check("R6 start held", v, 32'd1);
        wr(15'h104C, 32'h1); check("R6 no relaunch", {31'd0, bkd_start_o}, 32'd0);

        // R8 cancel while busy
        wr(15'h0048, 32'h2); check("R8 wrong value", {31'd0, bkd_cancel_o}, 32'd0);
        wr(15'h0048, 32'h1); check("R8 cancel pulse", {31'd0, bkd_cancel_o}, 32'd1);
        @(negedge clk);      check("R8 cancel single", {31'd0, bkd_cancel_o}, 32'd0);

        // R9 clean completion
        complete(1'b0);
        rd(15'h004C, v); check("R9 start cleared", v, 32'd0);
        rd(15'h0044, v); check("R9 no fatal", v, 32'd2);
        wr(15'h0048, 32'h1); check("R8 cancel idle ignored", {31'd0, bkd_cancel_o}, 32'd0);

        // R9 stray completion with error ignored
        complete(1'b1);
        rd(15'h0044, v); check("R9 stray done", v, 32'd2);

        // R9 error completion
        wr(15'h104C, 32'h1); check("R9 relaunch", {31'd0, bkd_start_o}, 32'd1);
        complete(1'b1);
        rd(15'h0044, v); check("R9 fatal set", v, 32'd3);
        rd(15'h004C, v); check("R9 start cleared err", v, 32'd0);

        // R1 reset returns defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(15'h0044, v); check("R1 post-reset ctl", v, 32'd2);
        rd(15'h0000, v); check("R1 post-reset status", v, 32'h80);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule